// File: doc/BRIEF.md
# ADC Offset/Gain Calibration Controller

This block sits after the digital filter of two sigma-delta converters, a primary and an auxiliary, and before their result registers. It keeps one offset coefficient and one gain coefficient for each converter. In the first clock cycle after reset, it copies factory coefficient values from a non-volatile port into those registers. During normal operation it corrects each filter word. It subtracts the converter's offset from the word, then scales the difference by the converter's gain. The corrected value is written to that converter's result register, and the converter's ready flag is raised.

On command, the block runs one of four calibration modes: internal zero-scale, internal full-scale, system zero-scale or system full-scale. The converters that take part are the ones whose enable inputs are high when the command is accepted. While a calibration runs, the block does three things. It selects the modulator input: an on-chip zero or full-scale reference for the internal modes, and the external pins for the system modes. It forces the slowest filter rate. It captures the next filter word of each participating converter into that converter's offset register (zero-scale modes) or gain register (full-scale modes). Each capture raises the same ready flag that a conversion raises. When every participating converter has delivered its word, the mode returns to idle and the programmed rate is selected again.

Top module: `adc_cal`

## Requirements
- R1: In the first clock cycle after reset is released, the block loads each converter's offset and gain registers from the factory ports (`nvOffPri`, `nvGainPri`, `nvOffAux`, `nvGainAux`). While reset is asserted, both result registers read 0, both ready flags read 0, `irq` reads 0, `busyMode` reads 0 and `inSel` reads 0.
- R2: The `calMode` encoding is: 0 idle, 1 internal zero-scale, 2 internal full-scale, 3 system zero-scale, 4 system full-scale. Values 5 to 7 are not modes, and a start carrying one of them is ignored. While a mode runs, `busyMode` shows its code. `inSel` is 1 (on-chip zero reference) in mode 1, 2 (on-chip full-scale reference) in mode 2, and 0 (external pins) at all other times.
- R3: While `busyMode` is not 0, `filtRate` is all ones (the slowest rate). At all other times `filtRate` equals `rateCfg`.
- R4: During a zero-scale mode, the next filter word from each participating converter is written to that converter's offset register. During a full-scale mode, that word is written to the converter's gain register. Later conversions then use the new coefficient.
- R5: A converter whose enable input is low when a start is accepted keeps its coefficients through that calibration, and its filter words are corrected as normal conversions. A start with both enable inputs low is ignored, and `busyMode` stays 0.
- R6: A normal conversion word x on `filtData` with `filtChan` c (0 primary, 1 auxiliary) gives the result round((x - offset) * gain / 2^23), where x and offset are two's-complement values and gain is unsigned, so 0x800000 means unity. Rounding adds 2^22 before an arithmetic shift. The result is saturated to the range -2^23 to 2^23-1. It appears in `resPri` or `resAux` one cycle after the word, with the matching ready flag set in the same cycle.
- R7: A calibration capture raises the ready flag of the captured converter and leaves its result register unchanged. `busyMode` returns to 0 on the clock edge that captures the last pending converter's word.
- R8: A ready flag stays set until its bit of `rdyClr` is high (bit 0 primary, bit 1 auxiliary). When a set and a clear arrive in the same cycle, the set wins. `irq` is the OR of the two ready flags.
- R9: A start issued while a calibration is running is ignored. The running mode and its set of pending converters are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| nvOffPri | input | 24 | Factory offset for the primary converter |
| nvGainPri | input | 24 | Factory gain for the primary converter |
| nvOffAux | input | 24 | Factory offset for the auxiliary converter |
| nvGainAux | input | 24 | Factory gain for the auxiliary converter |
| enPri | input | 1 | Primary converter takes part in a calibration |
| enAux | input | 1 | Auxiliary converter takes part in a calibration |
| calStart | input | 1 | Start a calibration with the code on calMode |
| calMode | input | 3 | Calibration mode code |
| rateCfg | input | 4 | Programmed filter rate |
| filtValid | input | 1 | Filter word strobe |
| filtChan | input | 1 | Converter of the filter word (0 primary, 1 auxiliary) |
| filtData | input | 24 | Filter word, two's complement |
| rdyClr | input | 2 | Clear the ready flags (bit 0 primary, bit 1 auxiliary) |
| inSel | output | 2 | Modulator input select |
| filtRate | output | 4 | Filter rate in effect |
| busyMode | output | 3 | Running mode code, 0 when idle |
| resPri | output | 24 | Corrected primary result |
| resAux | output | 24 | Corrected auxiliary result |
| rdyPri | output | 1 | Primary ready flag |
| rdyAux | output | 1 | Auxiliary ready flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that the input select and the forced slowest rate follow the running mode. They also check that a ready flag rises only after a filter word for its converter, that a flag holds until it is cleared, that `irq` tracks the flags, and that a start is refused when the block is busy or no converter is enabled. Only the bench scenarios can show the values involved. These are the corrected numbers, including rounding and saturation at both ends of the range. They also include the factory coefficients in use after reset, the captured coefficients taking effect in later conversions, and the disabled converter keeping its coefficients.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;
  localparam int NCONV  = 2;
  localparam int MODE_W = 3;
  localparam int SEL_W  = 2;

  localparam logic [MODE_W-1:0] MODE_IDLE  = 3'd0;
  localparam logic [MODE_W-1:0] MODE_IZERO = 3'd1;
  localparam logic [MODE_W-1:0] MODE_IFULL = 3'd2;
  localparam logic [MODE_W-1:0] MODE_SZERO = 3'd3;
  localparam logic [MODE_W-1:0] MODE_SFULL = 3'd4;

  localparam logic [SEL_W-1:0] SEL_PINS = 2'd0;
  localparam logic [SEL_W-1:0] SEL_ZREF = 2'd1;
  localparam logic [SEL_W-1:0] SEL_FREF = 2'd2;

  typedef enum logic [1:0] {ST_LOAD, ST_IDLE, ST_CAL} ctrl_state_t;

  typedef struct packed {
    logic             loadNv;
    logic [NCONV-1:0] capOff;
    logic [NCONV-1:0] capGain;
    logic [NCONV-1:0] conv;
  } strobe_t;
endpackage

// File: rtl/adc_cal_corrector.sv
module adc_cal_corrector #(
  parameter int DW = 24
) (
  input  logic [DW-1:0] dataIn,
  input  logic [DW-1:0] offset,
  input  logic [DW-1:0] gain,
  output logic [DW-1:0] dataOut
);
  localparam int FRAC = DW - 1;
  localparam int PW   = 2 * DW + 3;
  localparam logic signed [PW-1:0] MAXV = (PW'(1) <<< (DW - 1)) - PW'(1);
  localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FRAC - 1);

  logic signed [DW:0]   diff;
  logic signed [DW+1:0] gainS;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] rounded;
  logic signed [PW-1:0] scaled;

  assign diff    = $signed({dataIn[DW-1], dataIn}) - $signed({offset[DW-1], offset});
  assign gainS   = $signed({2'b00, gain});
  assign prod    = PW'(diff) * PW'(gainS);
  assign rounded = prod + HALF;
  assign scaled  = rounded >>> FRAC;

  always_comb begin
    if (scaled > MAXV)      dataOut = MAXV[DW-1:0];
    else if (scaled < MINV) dataOut = MINV[DW-1:0];
    else                    dataOut = scaled[DW-1:0];
  end
endmodule

// File: rtl/adc_cal_control.sv
module adc_cal_control
  import adc_cal_pkg::*;
#(
  parameter int RATE_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NCONV-1:0]    enMask,
  input  logic                calStart,
  input  logic [MODE_W-1:0]   calMode,
  input  logic [RATE_W-1:0]   rateCfg,
  input  logic                filtValid,
  input  logic                filtChan,
  output strobe_t             stb,
  output logic [SEL_W-1:0]    inSel,
  output logic [RATE_W-1:0]   filtRate,
  output logic [MODE_W-1:0]   busyMode
);
  ctrl_state_t        state;
  logic [MODE_W-1:0]  modeR;
  logic [NCONV-1:0]   pend;
  logic [NCONV-1:0]   chanHot;
  logic [NCONV-1:0]   pendNext;
  logic               modeOk;
  logic               startOk;
  logic               hit;
  logic               zeroMode;

  assign chanHot  = NCONV'(1) << filtChan;
  assign modeOk   = (calMode >= MODE_IZERO) && (calMode <= MODE_SFULL);
  assign startOk  = calStart && modeOk && (|enMask);
  assign hit      = (state == ST_CAL) && filtValid && (|(pend & chanHot));
  assign pendNext = pend & ~chanHot;
  assign zeroMode = (modeR == MODE_IZERO) || (modeR == MODE_SZERO);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_LOAD;
      modeR <= MODE_IDLE;
      pend  <= '0;
    end else begin
      case (state)
        ST_LOAD: state <= ST_IDLE;
        ST_IDLE: begin
          if (startOk) begin
            state <= ST_CAL;
            modeR <= calMode;
            pend  <= enMask;
          end
        end
        ST_CAL: begin
          if (hit) begin
            pend <= pendNext;
            if (pendNext == '0) begin
              state <= ST_IDLE;
              modeR <= MODE_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb         = '0;
    stb.loadNv  = (state == ST_LOAD);
    stb.capOff  = (hit && zeroMode)  ? chanHot : '0;
    stb.capGain = (hit && !zeroMode) ? chanHot : '0;
    for (int c = 0; c < NCONV; c++) begin
      stb.conv[c] = filtValid && chanHot[c] &&
                    ((state == ST_IDLE) || ((state == ST_CAL) && !pend[c]));
    end
  end

  always_comb begin
    case (modeR)
      MODE_IZERO: inSel = SEL_ZREF;
      MODE_IFULL: inSel = SEL_FREF;
      default:    inSel = SEL_PINS;
    endcase
  end

  assign filtRate = (modeR != MODE_IDLE) ? '1 : rateCfg;
  assign busyMode = modeR;
endmodule

// File: rtl/adc_cal_datapath.sv
module adc_cal_datapath
  import adc_cal_pkg::*;
#(
  parameter int DW = 24
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    stb,
  input  logic [NCONV-1:0][DW-1:0]   nvOff,
  input  logic [NCONV-1:0][DW-1:0]   nvGain,
  input  logic [DW-1:0]              filtData,
  input  logic [NCONV-1:0]           rdyClr,
  output logic [NCONV-1:0][DW-1:0]   res,
  output logic [NCONV-1:0]           rdy
);
  for (genvar i = 0; i < NCONV; i++) begin : g_conv
    logic [DW-1:0] offR;
    logic [DW-1:0] gainR;
    logic [DW-1:0] resR;
    logic [DW-1:0] corr;
    logic          rdyR;

    adc_cal_corrector #(.DW(DW)) u_corr (
      .dataIn (filtData),
      .offset (offR),
      .gain   (gainR),
      .dataOut(corr)
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        offR  <= '0;
        gainR <= '0;
      end else if (stb.loadNv) begin
        offR  <= nvOff[i];
        gainR <= nvGain[i];
      end else begin
        if (stb.capOff[i])  offR  <= filtData;
        if (stb.capGain[i]) gainR <= filtData;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        resR <= '0;
        rdyR <= 1'b0;
      end else begin
        if (stb.conv[i]) resR <= corr;
        if (stb.conv[i] || stb.capOff[i] || stb.capGain[i]) rdyR <= 1'b1;
        else if (rdyClr[i])                                 rdyR <= 1'b0;
      end
    end

    assign res[i] = resR;
    assign rdy[i] = rdyR;
  end
endmodule

// File: rtl/adc_cal.sv
module adc_cal
  import adc_cal_pkg::*;
#(
  parameter int DW     = 24,
  parameter int RATE_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [DW-1:0]       nvOffPri,
  input  logic [DW-1:0]       nvGainPri,
  input  logic [DW-1:0]       nvOffAux,
  input  logic [DW-1:0]       nvGainAux,
  input  logic                enPri,
  input  logic                enAux,
  input  logic                calStart,
  input  logic [MODE_W-1:0]   calMode,
  input  logic [RATE_W-1:0]   rateCfg,
  input  logic                filtValid,
  input  logic                filtChan,
  input  logic [DW-1:0]       filtData,
  input  logic [NCONV-1:0]    rdyClr,
  output logic [SEL_W-1:0]    inSel,
  output logic [RATE_W-1:0]   filtRate,
  output logic [MODE_W-1:0]   busyMode,
  output logic [DW-1:0]       resPri,
  output logic [DW-1:0]       resAux,
  output logic                rdyPri,
  output logic                rdyAux,
  output logic                irq
);
  strobe_t                  stb;
  logic [NCONV-1:0][DW-1:0] res;
  logic [NCONV-1:0]         rdy;

  adc_cal_control #(.RATE_W(RATE_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enMask   ({enAux, enPri}),
    .calStart (calStart),
    .calMode  (calMode),
    .rateCfg  (rateCfg),
    .filtValid(filtValid),
    .filtChan (filtChan),
    .stb      (stb),
    .inSel    (inSel),
    .filtRate (filtRate),
    .busyMode (busyMode)
  );

  adc_cal_datapath #(.DW(DW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .nvOff   ({nvOffAux, nvOffPri}),
    .nvGain  ({nvGainAux, nvGainPri}),
    .filtData(filtData),
    .rdyClr  (rdyClr),
    .res     (res),
    .rdy     (rdy)
  );

  assign resPri = res[0];
  assign resAux = res[1];
  assign rdyPri = rdy[0];
  assign rdyAux = rdy[1];
  assign irq    = |rdy;
endmodule

// File: rtl/adc_cal_chk.sv
module adc_cal_chk #(
  parameter int RATE_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              enPri,
  input logic              enAux,
  input logic              calStart,
  input logic [2:0]        calMode,
  input logic [RATE_W-1:0] rateCfg,
  input logic              filtValid,
  input logic              filtChan,
  input logic [1:0]        rdyClr,
  input logic [1:0]        inSel,
  input logic [RATE_W-1:0] filtRate,
  input logic [2:0]        busyMode,
  input logic              rdyPri,
  input logic              rdyAux,
  input logic              irq
);
  AST_SEL_ZREF: assert property (@(posedge clk) disable iff (!rstN)
    busyMode == 3'd1 |-> inSel == 2'd1); // R2
  AST_SEL_FREF: assert property (@(posedge clk) disable iff (!rstN)
    busyMode == 3'd2 |-> inSel == 2'd2); // R2
  AST_SEL_PINS: assert property (@(posedge clk) disable iff (!rstN)
    (busyMode != 3'd1 && busyMode != 3'd2) |-> inSel == 2'd0); // R2
  AST_RATE_SLOW: assert property (@(posedge clk) disable iff (!rstN)
    busyMode != 3'd0 |-> filtRate == '1); // R3
  AST_RATE_PROG: assert property (@(posedge clk) disable iff (!rstN)
    busyMode == 3'd0 |-> filtRate == rateCfg); // R3
  AST_NO_START_UNEN: assert property (@(posedge clk) disable iff (!rstN)
    (busyMode == 3'd0 && !enPri && !enAux) |=> busyMode == 3'd0); // R5
  AST_PRI_RDY_SRC: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdyPri) |-> ($past(filtValid) && !$past(filtChan))); // R6
  AST_AUX_RDY_SRC: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdyAux) |-> ($past(filtValid) && $past(filtChan))); // R6
  AST_PRI_RDY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rdyPri && !rdyClr[0]) |=> rdyPri); // R8
  AST_AUX_RDY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rdyAux && !rdyClr[1]) |=> rdyAux); // R8
  AST_IRQ_OR: assert property (@(posedge clk) disable iff (!rstN)
    irq == (rdyPri || rdyAux)); // R8
  AST_BUSY_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (busyMode != 3'd0 && calStart) |=> (busyMode == $past(busyMode) || busyMode == 3'd0)); // R9
  AST_BUSY_NO_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (busyMode != 3'd0 && !filtValid) |=> busyMode == $past(busyMode)); // R7
endmodule

bind adc_cal adc_cal_chk #(.RATE_W(RATE_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .enPri    (enPri),
  .enAux    (enAux),
  .calStart (calStart),
  .calMode  (calMode),
  .rateCfg  (rateCfg),
  .filtValid(filtValid),
  .filtChan (filtChan),
  .rdyClr   (rdyClr),
  .inSel    (inSel),
  .filtRate (filtRate),
  .busyMode (busyMode),
  .rdyPri   (rdyPri),
  .rdyAux   (rdyAux),
  .irq      (irq)
);

// File: tb/adc_cal_tb.sv
module adc_cal_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] nvOffPri = 24'h000100, nvGainPri = 24'h900000;
  logic [23:0] nvOffAux = 24'hFFFF00, nvGainAux = 24'h7C0000;
  logic        enPri = 1'b0, enAux = 1'b0, calStart = 1'b0;
  logic [2:0]  calMode = 3'd0;
  logic [3:0]  rateCfg = 4'h5;
  logic        filtValid = 1'b0, filtChan = 1'b0;
  logic [23:0] filtData = '0;
  logic [1:0]  rdyClr = 2'b00;
  logic [1:0]  inSel;
  logic [3:0]  filtRate;
  logic [2:0]  busyMode;
  logic [23:0] resPri, resAux;
  logic        rdyPri, rdyAux, irq;

  int nChk = 0, nFail = 0;
  logic [23:0] mOff [2];
  logic [23:0] mGain[2];

  adc_cal u_dut (.*);

  always #10 clk = ~clk;

  function automatic logic [23:0] model(input logic [23:0] x, input logic [23:0] off,
                                        input logic [23:0] g);
    longint d, p, r;
    d = longint'($signed(x)) - longint'($signed(off));
    p = d * longint'({40'b0, g});
    r = (p + (64'sd1 <<< 22)) >>> 23;
    if (r > 64'sd8388607)       r = 64'sd8388607;
    else if (r < -64'sd8388608) r = -64'sd8388608;
    return r[23:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  endtask

  task automatic sendWord(input logic c, input logic [23:0] d);
    @(negedge clk);
    filtValid = 1'b1; filtChan = c; filtData = d;
    @(negedge clk);
    filtValid = 1'b0;
  endtask

  task automatic convCheck(input logic c, input logic [23:0] d, input string req);
    logic [23:0] e;
    e = model(d, mOff[c], mGain[c]);
    sendWord(c, d);
    chk(req, c ? resAux : resPri, e);
    chk("R8 ready after word", c ? rdyAux : rdyPri, 1'b1);
  endtask

  task automatic startCal(input logic [2:0] m, input logic ep, input logic ea);
    @(negedge clk);
    calMode = m; enPri = ep; enAux = ea; calStart = 1'b1;
    @(negedge clk);
    calStart = 1'b0; enPri = 1'b0; enAux = 1'b0;
  endtask

  task automatic clearRdy();
    @(negedge clk);
    rdyClr = 2'b11;
    @(negedge clk);
    rdyClr = 2'b00;
  endtask

  initial begin
    #(200000 * 20);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    logic [23:0] keep;
    void'($urandom(32'h5eed_1234));
    mOff[0] = nvOffPri; mGain[0] = nvGainPri;
    mOff[1] = nvOffAux; mGain[1] = nvGainAux;
    #35;
    chk("R1 reset resPri", resPri, 24'h0);
    chk("R1 reset resAux", resAux, 24'h0);
    chk("R1 reset ready", {rdyPri, rdyAux, irq}, 3'b000);
    chk("R1 reset busyMode", busyMode, 3'd0);
    chk("R1 reset inSel", inSel, 2'd0);
    @(negedge clk); rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R3 idle rate", filtRate, rateCfg);

    convCheck(1'b0, 24'h123456, "R1 factory primary");
    convCheck(1'b1, 24'hF00000, "R1 factory auxiliary");

    for (int k = 0; k < 40; k++) begin
      logic c;
      c = 1'($urandom % 2);
      convCheck(c, 24'($urandom), "R6 random conversion");
      if ($urandom % 4 == 0) begin
        clearRdy();
        chk("R8 clear", {rdyPri, rdyAux, irq}, 3'b000);
      end
    end

    convCheck(1'b0, 24'h7FFFFF, "R6 positive saturation");
    chk("R6 positive saturation value", resPri, 24'h7FFFFF);
    convCheck(1'b0, 24'h800000, "R6 negative saturation");
    chk("R6 negative saturation value", resPri, 24'h800000);

    clearRdy();
    chk("R8 ready cleared", {rdyPri, rdyAux, irq}, 3'b000);
    @(negedge clk);
    filtValid = 1'b1; filtChan = 1'b0; filtData = 24'h000200; rdyClr = 2'b01;
    @(negedge clk);
    filtValid = 1'b0; rdyClr = 2'b00;
    chk("R8 set wins over clear", rdyPri, 1'b1);
    chk("R8 irq follows", irq, 1'b1);
    clearRdy();

    // internal zero-scale, primary only
    startCal(3'd1, 1'b1, 1'b0);
    chk("R2 busy izero", busyMode, 3'd1);
    chk("R2 inSel zero ref", inSel, 2'd1);
    chk("R3 slowest rate", filtRate, 4'hF);
    convCheck(1'b1, 24'h0A0000, "R5 aux normal during cal");
    keep = resPri;
    sendWord(1'b0, 24'h000400);
    mOff[0] = 24'h000400;
    chk("R7 idle after capture", busyMode, 3'd0);
    chk("R7 ready on capture", rdyPri, 1'b1);
    chk("R7 result unchanged", resPri, keep);
    chk("R3 rate restored", filtRate, rateCfg);
    convCheck(1'b0, 24'h300000, "R4 new offset used");
    convCheck(1'b1, 24'h200000, "R5 aux coefficients kept");

    // internal full-scale, auxiliary only
    startCal(3'd2, 1'b0, 1'b1);
    chk("R2 inSel full ref", inSel, 2'd2);
    sendWord(1'b1, 24'hA00000);
    mGain[1] = 24'hA00000;
    chk("R7 idle after aux capture", busyMode, 3'd0);
    convCheck(1'b1, 24'h100000, "R4 new gain used");
    convCheck(1'b0, 24'h100000, "R5 primary gain kept");

    // system zero-scale, both converters, restart ignored while busy
    startCal(3'd3, 1'b1, 1'b1);
    chk("R2 busy szero", busyMode, 3'd3);
    chk("R2 inSel pins", inSel, 2'd0);
    sendWord(1'b0, 24'hFFFE00);
    mOff[0] = 24'hFFFE00;
    chk("R7 still busy with aux pending", busyMode, 3'd3);
    startCal(3'd2, 1'b1, 1'b1);
    chk("R9 restart ignored", busyMode, 3'd3);
    sendWord(1'b0, 24'h000777);
    chk("R9 primary not re-armed", busyMode, 3'd3);
    convCheck(1'b0, 24'h050000, "R9 primary converts normally");
    sendWord(1'b1, 24'h000050);
    mOff[1] = 24'h000050;
    chk("R7 idle after both", busyMode, 3'd0);
    convCheck(1'b0, 24'h222222, "R4 sys offset primary");
    convCheck(1'b1, 24'hD00000, "R4 sys offset aux");

    // system full-scale
    startCal(3'd4, 1'b1, 1'b0);
    chk("R2 busy sfull", busyMode, 3'd4);
    sendWord(1'b0, 24'h880000);
    mGain[0] = 24'h880000;
    convCheck(1'b0, 24'h400000, "R4 sys gain primary");

    // rejected starts
    startCal(3'd4, 1'b0, 1'b0);
    chk("R5 start without enable ignored", busyMode, 3'd0);
    startCal(3'd6, 1'b1, 1'b1);
    chk("R2 invalid code ignored", busyMode, 3'd0);
    convCheck(1'b0, 24'h012345, "R5 coefficients after rejected start");
    convCheck(1'b1, 24'h012345, "R5 aux after rejected start");

    finishRun();
  end
endmodule